// File: doc/BRIEF.md
# Peripheral Control Register Window

This block is the bus-side slave for a bank of 16-bit control registers that belong to many different peripherals but are addressed as one 256-byte window. Software can relocate the window by programming a base value. The block compares the upper address bits with that base and turns the offset inside the window into a one-hot write or read strobe for a single register slot. It forwards the write data and byte lanes to the peripherals and returns the selected register's 16-bit value to the bus.

The block comes in two builds, chosen by a parameter. On the 16-bit bus build, byte enables select the lanes that a write updates, so an aligned word write changes both bytes in one access. On the 8-bit bus build, the CPU issues its register writes as byte writes, but the bus carries the whole 16-bit accumulator value. Every write therefore updates the full register, whatever the byte information says. In both builds, reads return a full word.

The block decodes each request in two stages. The request is sampled on clock edge n. Peripheral strobes are valid after edge n. The acknowledge and read data are valid after edge n+1. Every access that falls inside the window is acknowledged, so an odd offset or an empty slot cannot stall the bus.

Top module: `ctl_reg_window`

## Requirements
- R1: A request (bus_wr or bus_rd high) produces strobes or an acknowledge only when bus_addr[ADDR_W-1:8] equals win_base. Requests outside the window produce no strobe and no acknowledge.
- R2: A request sampled on edge n at even offset 2k, where slot k is populated (SLOT_MAP bit k set), raises bit k of reg_wr (for a write) or of reg_rd (for a read) for the one cycle after edge n. No other strobe bit is raised.
- R3: On the 16-bit build (BUS_BYTES=2), a write strobe carries reg_wdata equal to bus_wdata and reg_wbe equal to bus_be (bit 0 is the low byte, bit 1 is the high byte). A write with bus_be=2'b00 raises no strobe.
- R4: On the 8-bit build (BUS_BYTES=1), every strobed write carries the full 16-bit bus_wdata with reg_wbe=2'b11, whatever the value of bus_be.
- R5: For a read of a populated slot, bus_rdata after edge n+1 equals that slot's 16-bit word in reg_rdata_flat (slot k occupies bits 16k+15:16k). bus_be has no effect on reads.
- R6: An aligned access to an unpopulated slot inside the window raises no strobe, is acknowledged, and returns bus_rdata=0.
- R7: An access at an odd offset inside the window raises no strobe, is acknowledged, and returns bus_rdata=0.
- R8: Every in-window request sampled on edge n raises bus_ack for exactly the one cycle after edge n+1. A write access returns bus_rdata=0.
- R9: If bus_wr and bus_rd are both high, the write takes effect, no read strobe is raised, and bus_rdata is 0.
- R10: While rst_n is low, all strobes, bus_ack and bus_rdata are 0.
- R11: Changing win_base moves the window: the old base no longer decodes, and the new base does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | ADDR_W-8 | Relocatable window base (upper address bits) |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data (full accumulator word) |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completion pulse |
| reg_wr | output | SLOT_CNT | One-hot per-slot write strobe |
| reg_rd | output | SLOT_CNT | One-hot per-slot read strobe |
| reg_wdata | output | 16 | Write data to the peripherals |
| reg_wbe | output | 2 | Byte lanes to update |
| reg_rdata_flat | input | SLOT_CNT*16 | Current value of every slot, concatenated |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One copy uses BUS_BYTES=2 and the other uses BUS_BYTES=1, and both use a 20-bit address and a mixed population map. This lets the same request show where the two builds differ in lane handling (R3 against R4), while the decode, alignment and empty-slot handling must match. The map leaves gaps in the lowest slots and fills the top slot. This puts the empty-slot and last-offset cases within reach, and a change of base tests relocation.

// File: rtl/ctl_reg_window_pkg.sv
package ctl_reg_window_pkg;
   localparam int WIN_BYTES  = 256;
   localparam int WORD_BITS  = 16;
   localparam int SLOT_CNT   = WIN_BYTES / 2;
   localparam int SLOT_IDX_W = $clog2(SLOT_CNT);

   typedef struct packed {
      logic                  hit;
      logic                  wr;
      logic                  rd;
      logic                  slot_ok;
      logic [SLOT_IDX_W-1:0] slot;
   } crw_dec_t;
endpackage

// File: rtl/crw_decode.sv
module crw_decode
   import ctl_reg_window_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter int                BUS_BYTES = 2,
   parameter logic [SLOT_CNT-1:0] SLOT_MAP = '1
) (
   input  logic [ADDR_W-9:0] base,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [1:0]        be,
   output crw_dec_t          dec
);
   logic in_win;
   logic aligned;
   logic populated;
   logic lanes_ok;
   logic [SLOT_IDX_W-1:0] idx;

   assign idx       = addr[7:1];
   assign in_win    = (addr[ADDR_W-1:8] == base);
   assign aligned   = ~addr[0];
   assign populated = SLOT_MAP[idx];

   generate
      if (BUS_BYTES == 2) begin : g_lane16
         assign lanes_ok = ~wr | (|be);
      end else begin : g_lane8
         assign lanes_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.hit     = in_win & (wr | rd);
      dec.wr      = wr;
      dec.rd      = rd & ~wr;
      dec.slot_ok = dec.hit & aligned & populated & lanes_ok;
      dec.slot    = idx;
   end
endmodule

// File: rtl/crw_lanes.sv
module crw_lanes #(
   parameter int BUS_BYTES = 2
) (
   input  logic [15:0] wdata_in,
   input  logic [1:0]  be_in,
   output logic [15:0] wdata_out,
   output logic [1:0]  be_out
);
   generate
      if (BUS_BYTES == 2) begin : g_word_bus
         assign wdata_out = wdata_in;
         assign be_out    = be_in;
      end else begin : g_byte_bus
         logic unused_be;
         assign unused_be = ^be_in;
         assign wdata_out = wdata_in;
         assign be_out    = 2'b11;
      end
   endgenerate
endmodule

// File: rtl/crw_rmux.sv
module crw_rmux #(
   parameter int SLOTS = 128,
   parameter int W     = 16
) (
   input  logic [SLOTS-1:0]   sel,
   input  logic [SLOTS*W-1:0] flat,
   output logic [W-1:0]       word
);
   always_comb begin
      word = '0;
      for (int i = 0; i < SLOTS; i++) begin
         word = word | ({W{sel[i]}} & flat[i*W +: W]);
      end
   end
endmodule

// File: rtl/ctl_reg_window.sv
module ctl_reg_window
   import ctl_reg_window_pkg::*;
#(
   parameter int                  ADDR_W    = 20,
   parameter int                  BUS_BYTES = 2,
   parameter logic [SLOT_CNT-1:0] SLOT_MAP  = 128'hFFFF_0F0F_00FF_3C3C_FFFF_0000_A5A5_7FFF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-9:0]            win_base,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [1:0]                   bus_be,
   input  logic [15:0]                  bus_wdata,
   output logic [15:0]                  bus_rdata,
   output logic                         bus_ack,
   output logic [SLOT_CNT-1:0]          reg_wr,
   output logic [SLOT_CNT-1:0]          reg_rd,
   output logic [15:0]                  reg_wdata,
   output logic [1:0]                   reg_wbe,
   input  logic [SLOT_CNT*WORD_BITS-1:0] reg_rdata_flat
);
   generate
      if (BUS_BYTES != 1 && BUS_BYTES != 2) begin : g_bad_bus
         $error("ctl_reg_window: BUS_BYTES must be 1 or 2");
      end
      if (ADDR_W <= 8) begin : g_bad_addr
         $error("ctl_reg_window: ADDR_W must exceed the window width");
      end
   endgenerate

   crw_dec_t            dec;
   logic [15:0]         lane_data;
   logic [1:0]          lane_be;
   logic                s1_hit;
   logic                s1_wr;
   logic                s1_rd;
   logic [SLOT_CNT-1:0] s1_sel;
   logic [15:0]         s1_wdata;
   logic [1:0]          s1_be;
   logic [15:0]         mux_word;

   crw_decode #(
      .ADDR_W   (ADDR_W),
      .BUS_BYTES(BUS_BYTES),
      .SLOT_MAP (SLOT_MAP)
   ) u_decode (
      .base(win_base),
      .addr(bus_addr),
      .wr  (bus_wr),
      .rd  (bus_rd),
      .be  (bus_be),
      .dec (dec)
   );

   crw_lanes #(.BUS_BYTES(BUS_BYTES)) u_lanes (
      .wdata_in (bus_wdata),
      .be_in    (bus_be),
      .wdata_out(lane_data),
      .be_out   (lane_be)
   );

   // Stage 1: strobes toward the peripherals
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_hit   <= 1'b0;
         s1_wr    <= 1'b0;
         s1_rd    <= 1'b0;
         s1_sel   <= '0;
         s1_wdata <= '0;
         s1_be    <= '0;
      end else begin
         s1_hit   <= dec.hit;
         s1_wr    <= dec.hit & dec.wr;
         s1_rd    <= dec.hit & dec.rd;
         s1_sel   <= dec.slot_ok ? (SLOT_CNT'(1) << dec.slot) : '0;
         s1_wdata <= lane_data;
         s1_be    <= lane_be;
      end
   end

   assign reg_wr    = s1_wr ? s1_sel : '0;
   assign reg_rd    = s1_rd ? s1_sel : '0;
   assign reg_wdata = s1_wdata;
   assign reg_wbe   = s1_be;

   crw_rmux #(.SLOTS(SLOT_CNT), .W(WORD_BITS)) u_rmux (
      .sel (reg_rd),
      .flat(reg_rdata_flat),
      .word(mux_word)
   );

   // Stage 2: completion toward the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= s1_hit;
         bus_rdata <= mux_word;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_wr | reg_rd)); // R2
   AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((|reg_wr) && (|reg_rd))); // R9
   AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((|reg_wr) || (|reg_rd)) |=> bus_ack); // R8
   AST_QUIET_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && !$past(|reg_rd)) |-> (bus_rdata == 16'h0000)); // R6
   AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_wr) |-> (reg_wbe != 2'b00)); // R3
endmodule

// File: tb/ctl_reg_window_bench.sv
module ctl_reg_window_bench;
   localparam int AW = 20;
   localparam int NS = 128;
   localparam logic [NS-1:0] MAP = 128'hFFFF_0F0F_00FF_3C3C_FFFF_0000_A5A5_7FFF;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [AW-9:0] base;
   logic [AW-1:0] addr;
   logic          wr, rd;
   logic [1:0]    be;
   logic [15:0]   wdata;
   logic [NS*16-1:0] rflat;

   logic [15:0] rdata_w, rdata_b;
   logic        ack_w, ack_b;
   logic [NS-1:0] wrs_w, rds_w, wrs_b, rds_b;
   logic [15:0] rwd_w, rwd_b;
   logic [1:0]  rbe_w, rbe_b;

   int vecs = 0;
   int errs = 0;
   bit done = 0;

   ctl_reg_window #(.ADDR_W(AW), .BUS_BYTES(2), .SLOT_MAP(MAP)) u_ctl_reg_window (
      .clk(clk), .rst_n(rst_n), .win_base(base), .bus_addr(addr), .bus_wr(wr),
      .bus_rd(rd), .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata_w),
      .bus_ack(ack_w), .reg_wr(wrs_w), .reg_rd(rds_w), .reg_wdata(rwd_w),
      .reg_wbe(rbe_w), .reg_rdata_flat(rflat));

   ctl_reg_window #(.ADDR_W(AW), .BUS_BYTES(1), .SLOT_MAP(MAP)) u_ctl_reg_window_b8 (
      .clk(clk), .rst_n(rst_n), .win_base(base), .bus_addr(addr), .bus_wr(wr),
      .bus_rd(rd), .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata_b),
      .bus_ack(ack_b), .reg_wr(wrs_b), .reg_rd(rds_b), .reg_wdata(rwd_b),
      .reg_wbe(rbe_b), .reg_rdata_flat(rflat));

   function automatic logic [15:0] slot_val(input int i);
      return 16'h5A00 ^ (16'(i) * 16'h0107);
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One request, then checks on both builds at the two result cycles
   task automatic access(input logic w, input logic r, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] b);
      logic in_win, ok_al, pop, hit;
      logic [6:0] k;
      logic [NS-1:0] oh, ew_w, er_w, ew_b, er_b;
      logic [15:0] erd;
      in_win = (a[AW-1:8] == base);
      hit    = in_win && (w || r);
      ok_al  = !a[0];
      k      = a[7:1];
      pop    = MAP[k];
      oh     = NS'(1) << k;
      ew_w = (hit && w && ok_al && pop && (b != 2'b00)) ? oh : '0;
      ew_b = (hit && w && ok_al && pop) ? oh : '0;
      er_w = (hit && !w && r && ok_al && pop) ? oh : '0;
      er_b = er_w;
      erd  = (er_w != '0) ? slot_val(int'(k)) : 16'h0000;
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr = 0; rd = 0;
      chk("R1/R2/R6/R7/R9 wr strobe w16", 128'(wrs_w), 128'(ew_w));
      chk("R1/R2/R6/R7/R9 rd strobe w16", 128'(rds_w), 128'(er_w));
      chk("R1/R2/R4 wr strobe b8", 128'(wrs_b), 128'(ew_b));
      chk("R2/R9 rd strobe b8", 128'(rds_b), 128'(er_b));
      chk("R8 no early ack", 128'({ack_w, ack_b}), 128'(0));
      if (ew_w != '0) begin
         chk("R3 wdata w16", 128'(rwd_w), 128'(d));
         chk("R3 wbe w16", 128'(rbe_w), 128'(b));
      end
      if (ew_b != '0) begin
         chk("R4 wdata b8", 128'(rwd_b), 128'(d));
         chk("R4 wbe b8", 128'(rbe_b), 128'(2'b11));
      end
      @(negedge clk);
      chk("R1/R8 ack w16", 128'(ack_w), 128'(hit));
      chk("R1/R8 ack b8", 128'(ack_b), 128'(hit));
      chk("R5/R6/R7/R9 rdata w16", 128'(rdata_w), 128'(erd));
      chk("R5/R6/R7/R9 rdata b8", 128'(rdata_b), 128'(erd));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; base = 12'h0FF; addr = '0; wr = 0; rd = 0; be = 0; wdata = 0;
      for (int i = 0; i < NS; i++) rflat[i*16 +: 16] = slot_val(i);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset strobes", 128'(wrs_w | rds_w | wrs_b | rds_b), 128'(0));
      chk("R10 reset ack/rdata", 128'({ack_w, ack_b, rdata_w, rdata_b}), 128'(0));
      rst_n = 1;
      // directed corners
      access(1, 0, {base, 8'h00}, 16'hBEEF, 2'b11);  // R3 word write slot 0
      access(1, 0, {base, 8'h02}, 16'h1234, 2'b01);  // R3 low lane only
      access(1, 0, {base, 8'h04}, 16'h5678, 2'b00);  // R3 no lanes, R4 full
      access(0, 1, {base, 8'h06}, 16'h0000, 2'b00);  // R5 read, be ignored
      access(1, 0, {base, 8'h1E}, 16'hAAAA, 2'b11);  // R6 empty slot 15
      access(0, 1, {base, 8'h1E}, 16'h0000, 2'b11);  // R6 empty slot read
      access(1, 0, {base, 8'h07}, 16'h7777, 2'b11);  // R7 odd offset write
      access(0, 1, {base, 8'h09}, 16'h0000, 2'b11);  // R7 odd offset read
      access(0, 1, {base, 8'hFE}, 16'h0000, 2'b11);  // R5 top slot
      access(1, 1, {base, 8'h0A}, 16'hC3C3, 2'b10);  // R9 rd+wr
      access(1, 0, {base + 12'd1, 8'h00}, 16'h1111, 2'b11); // R1 outside
      base = 12'h0A5;                                // R11 relocation
      access(0, 1, {12'h0FF, 8'h00}, 16'h0000, 2'b11);
      access(0, 1, {12'h0A5, 8'h00}, 16'h0000, 2'b11);
      // constrained random
      for (int n = 0; n < 400; n++) begin
         logic [AW-9:0] hb;
         hb = ($urandom % 4 == 0) ? 12'($urandom) : base;
         access(1'($urandom), 1'($urandom), {hb, 8'($urandom)},
                16'($urandom), 2'($urandom));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule